// File: doc/BRIEF.md
# Two-Segment Flat Depth Prediction Evaluator

This block scores a two-region flat prediction of a square depth block. A raster stream of 8-bit depth samples enters together with one segment bit per sample. The block fills each of the two segments with the rounded mean of its own samples. It returns the per-sample difference between the original block and that flat reference, the total absolute distortion of the block, and the two fill values. A template-search controller feeds the same block once per candidate mask and keeps the candidate with the lowest distortion.

The evaluation takes two passes. During loading, the block stores every sample with its segment bit and adds up per-segment totals and population counts. Two serial dividers then form the segment means. A replay pass reads the stored samples back in arrival order and emits one residual per cycle. It adds the magnitudes into the distortion total. A single-cycle completion pulse marks the end of a block. The two fill values and the distortion total then stay unchanged until the next block is started.

Top module: `wseg_eval`

## Requirements
- R1: A segment bit of 0 places the sample in the first segment, whose fill value appears on `d1`. A bit of 1 places it in the second segment, whose fill value appears on `d2`. Every reference sample equals the fill value of its own segment.
- R2: Each fill value is (segment total + floor(count/2)) / count with integer division, which rounds halves upward.
- R3: A segment that receives no samples takes the rounded mean of the whole block, (block total + samples/2) / samples.
- R4: `res_data` is the original sample minus its segment's fill value, in 9-bit two's complement. Residuals leave one per `res_valid` cycle in the same raster order as the input, and there are exactly as many as there are samples in the block.
- R5: `sad` equals the sum of the absolute residuals over the whole block, up to 1024×255.
- R6: The size code `in_size`, taken with the start sample, selects the block edge: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32. A code above the largest size the parameters allow is clamped to that size.
- R7: `in_ready` is high while the block is idle or loading and low during division and replay. A sample offered while idle without `in_start` is ignored and changes no output.
- R8: `done` pulses for one cycle, one cycle after the last residual. After that, `d1`, `d2` and `sad` hold their values until a new start sample is accepted.
- R9: A start sample accepted during loading discards the partial block and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered this cycle |
| in_start | input | 1 | Offered sample is the first of a block |
| in_size | input | 2 | Block size code, sampled with the start sample |
| in_sample | input | SW | Unsigned depth sample |
| in_seg | input | 1 | Segment bit of the offered sample |
| in_ready | output | 1 | Block accepts samples |
| res_valid | output | 1 | Residual present on `res_data` |
| res_data | output | SW+1 | Signed residual |
| done | output | 1 | One-cycle end-of-block pulse |
| d1 | output | SW | Fill value of the first segment |
| d2 | output | SW | Fill value of the second segment |
| sad | output | SADW | Sum of absolute residuals |

## Verification
The assertions assume that a block begins with an asserted `in_start` and that the size code is meaningful only on that cycle. They also assume the source offers samples only while `in_ready` is high, so nothing is dropped during replay. The bench keeps to these rules. It drives every block as one unbroken run of samples starting with a flagged start sample, and it begins a new block only after completion has been seen. The one exception is the restart case, which opens a new block in the middle of loading, something loading is permitted to accept. The bench also offers stray unflagged samples only while the block is idle, where they must be ignored.

// File: rtl/wseg_pkg.sv
package wseg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_DIV,
      ST_PLAY,
      ST_DRAIN
   } wseg_state_e;

   localparam int SIZE_CODE_W = 2;
   localparam int MIN_EDGE_LOG2 = 2;

   function automatic logic [3:0] area_log2(input logic [SIZE_CODE_W-1:0] code);
      return 4'(2 * MIN_EDGE_LOG2) + {1'b0, code, 1'b0};
   endfunction

endpackage

// File: rtl/wseg_store.sv
module wseg_store #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 1024,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("wseg_store: DEPTH must be a power of two");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/wseg_divider.sv
module wseg_divider #(
   parameter int NW = 19,
   parameter int DW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          done,
   output logic [NW-1:0] quo
);

   localparam int STW = $clog2(NW + 1);

   generate
      if (NW < 2 || DW < 1) begin : g_bad_width
         $error("wseg_divider: widths too small");
      end
   endgenerate

   logic [NW-1:0]  q_sh;
   logic [DW-1:0]  rem;
   logic [DW-1:0]  den_q;
   logic [STW-1:0] step;
   logic           run;
   logic [DW:0]    trial;
   logic           take;

   assign trial = {rem, q_sh[NW-1]};
   assign take  = (trial >= {1'b0, den_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_sh  <= '0;
         rem   <= '0;
         den_q <= '0;
         step  <= '0;
         run   <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            q_sh  <= num;
            rem   <= '0;
            den_q <= den;
            step  <= '0;
            run   <= 1'b1;
         end else if (run) begin
            q_sh <= {q_sh[NW-2:0], take};
            rem  <= take ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
            step <= step + 1'b1;
            if (step == STW'(NW - 1)) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quo = q_sh;

endmodule

// File: rtl/wseg_resid.sv
module wseg_resid #(
   parameter int SW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_v,
   input  logic                 in_last,
   input  logic [SW-1:0]        sample,
   input  logic                 seg,
   input  logic [SW-1:0]        d1,
   input  logic [SW-1:0]        d2,
   output logic                 out_v,
   output logic                 out_last,
   output logic signed [SW:0]   res,
   output logic [SW-1:0]        mag
);

   logic [SW-1:0]      fill;
   logic signed [SW:0] diff;
   logic [SW-1:0]      mag_c;

   always_comb begin
      fill  = seg ? d2 : d1;
      diff  = $signed({1'b0, sample}) - $signed({1'b0, fill});
      mag_c = diff[SW] ? SW'(-diff) : diff[SW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v    <= 1'b0;
         out_last <= 1'b0;
         res      <= '0;
         mag      <= '0;
      end else begin
         out_v    <= in_v;
         out_last <= in_v & in_last;
         if (in_v) begin
            res <= diff;
            mag <= mag_c;
         end
      end
   end

endmodule

// File: rtl/wseg_eval.sv
module wseg_eval
   import wseg_pkg::*;
#(
   parameter int SW   = 8,
   parameter int NMAX = 32,
   parameter int SADW = SW + $clog2(NMAX * NMAX)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_start,
   input  logic [1:0]             in_size,
   input  logic [SW-1:0]          in_sample,
   input  logic                   in_seg,
   output logic                   in_ready,
   output logic                   res_valid,
   output logic signed [SW:0]     res_data,
   output logic                   done,
   output logic [SW-1:0]          d1,
   output logic [SW-1:0]          d2,
   output logic [SADW-1:0]        sad
);

   localparam int DEPTH    = NMAX * NMAX;
   localparam int AW       = $clog2(DEPTH);
   localparam int CW       = AW + 1;
   localparam int SUMW     = SW + AW;
   localparam int NW       = SUMW + 1;
   localparam int MAX_CODE = $clog2(NMAX) - MIN_EDGE_LOG2;

   generate
      if (NMAX < 4 || NMAX > 32 || (NMAX & (NMAX - 1)) != 0) begin : g_bad_nmax
         $error("wseg_eval: NMAX must be a power of two from 4 to 32");
      end
      if (SADW < SW + AW) begin : g_bad_sadw
         $error("wseg_eval: SADW too narrow for a full block");
      end
      if (SW < 2) begin : g_bad_sw
         $error("wseg_eval: SW too small");
      end
   endgenerate

   wseg_state_e           state;
   logic [1:0]            size_q;
   logic [1:0]            size_in;
   logic [3:0]            area_sh;
   logic [CW-1:0]         blk_total;
   logic [AW-1:0]         last_idx;
   logic [AW-1:0]         wr_idx;
   logic [AW-1:0]         rd_idx;
   logic [SUMW-1:0]       seg_sum [2];
   logic [CW-1:0]         seg_cnt [2];
   logic [SUMW:0]         tot_sum;
   logic [SW-1:0]         blk_mean;
   logic [SW-1:0]         seg_mean [2];
   logic [1:0]            div_done;
   logic                  div_go;
   logic                  accept;
   logic                  start_acc;
   logic                  load_acc;
   logic                  wr_en;
   logic [AW-1:0]         wr_addr;
   logic                  rd_en;
   logic [SW:0]           rd_word;
   logic                  rd_v;
   logic                  rd_last;
   logic                  rs_last;
   logic [SW-1:0]         rs_mag;

   // size decode and block geometry
   always_comb begin
      size_in   = (in_size > 2'(MAX_CODE)) ? 2'(MAX_CODE) : in_size;
      area_sh   = area_log2(size_q);
      blk_total = CW'(1) << area_sh;
      last_idx  = AW'(blk_total - 1'b1);
      tot_sum   = (SUMW + 1)'(seg_sum[0]) + (SUMW + 1)'(seg_sum[1])
                + (SUMW + 1)'(blk_total >> 1);
      blk_mean  = SW'(tot_sum >> area_sh);
   end

   // handshake
   assign in_ready  = (state == ST_IDLE) || (state == ST_LOAD);
   assign accept    = in_valid & in_ready;
   assign start_acc = accept & in_start;
   assign load_acc  = accept & ~in_start & (state == ST_LOAD);

   // per-segment mean dividers
   generate
      for (genvar g = 0; g < 2; g++) begin : g_seg
         logic [NW-1:0] num;
         logic [NW-1:0] quo;
         assign num = NW'(seg_sum[g]) + NW'(seg_cnt[g] >> 1);
         wseg_divider #(
            .NW (NW),
            .DW (CW)
         ) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_go),
            .num   (num),
            .den   (seg_cnt[g]),
            .done  (div_done[g]),
            .quo   (quo)
         );
         assign seg_mean[g] = (seg_cnt[g] == '0) ? blk_mean : quo[SW-1:0];
      end
   endgenerate

   // sample buffer
   assign wr_en   = start_acc | load_acc;
   assign wr_addr = start_acc ? '0 : wr_idx;
   assign rd_en   = (state == ST_PLAY);

   wseg_store #(
      .WIDTH (SW + 1),
      .DEPTH (DEPTH)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data ({in_seg, in_sample}),
      .rd_en   (rd_en),
      .rd_addr (rd_idx),
      .rd_data (rd_word)
   );

   // residual stage
   wseg_resid #(
      .SW (SW)
   ) u_resid (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (rd_v),
      .in_last  (rd_last),
      .sample   (rd_word[SW-1:0]),
      .seg      (rd_word[SW]),
      .d1       (d1),
      .d2       (d2),
      .out_v    (res_valid),
      .out_last (rs_last),
      .res      (res_data),
      .mag      (rs_mag)
   );

   // control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         size_q     <= '0;
         wr_idx     <= '0;
         rd_idx     <= '0;
         seg_sum[0] <= '0;
         seg_sum[1] <= '0;
         seg_cnt[0] <= '0;
         seg_cnt[1] <= '0;
         div_go     <= 1'b0;
         d1         <= '0;
         d2         <= '0;
         sad        <= '0;
         done       <= 1'b0;
         rd_v       <= 1'b0;
         rd_last    <= 1'b0;
      end else begin
         div_go  <= 1'b0;
         done    <= res_valid & rs_last;
         rd_v    <= (state == ST_PLAY);
         rd_last <= (state == ST_PLAY) && (rd_idx == last_idx);
         if (res_valid) sad <= sad + SADW'(rs_mag);

         if (start_acc) begin
            size_q     <= size_in;
            seg_sum[0] <= in_seg ? '0 : SUMW'(in_sample);
            seg_sum[1] <= in_seg ? SUMW'(in_sample) : '0;
            seg_cnt[0] <= in_seg ? '0 : CW'(1);
            seg_cnt[1] <= in_seg ? CW'(1) : '0;
            wr_idx     <= AW'(1);
            sad        <= '0;
            state      <= ST_LOAD;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_LOAD: begin
                  if (load_acc) begin
                     seg_sum[in_seg] <= seg_sum[in_seg] + SUMW'(in_sample);
                     seg_cnt[in_seg] <= seg_cnt[in_seg] + 1'b1;
                     wr_idx          <= wr_idx + 1'b1;
                     if (wr_idx == last_idx) begin
                        state  <= ST_DIV;
                        div_go <= 1'b1;
                     end
                  end
               end
               ST_DIV: begin
                  if (div_done[0]) begin
                     d1     <= seg_mean[0];
                     d2     <= seg_mean[1];
                     rd_idx <= '0;
                     state  <= ST_PLAY;
                  end
               end
               ST_PLAY: begin
                  rd_idx <= rd_idx + 1'b1;
                  if (rd_idx == last_idx) state <= ST_DRAIN;
               end
               ST_DRAIN: begin
                  if (res_valid && rs_last) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/wseg_eval_chk.sv
module wseg_eval_chk #(
   parameter int SW   = 8,
   parameter int SADW = 18
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_start,
   input logic                 in_ready,
   input logic                 res_valid,
   input logic signed [SW:0]   res_data,
   input logic                 done,
   input logic [SW-1:0]        d1,
   input logic [SW-1:0]        d2,
   input logic [SADW-1:0]      sad
);

   logic held;
   logic start_acc;

   assign start_acc = in_valid & in_ready & in_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held <= 1'b0;
      else if (start_acc) held <= 1'b0;
      else if (done)      held <= 1'b1;
   end

   assert_done_follows_res_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(res_valid));

   assert_done_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && res_valid));

   assert_results_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      held && !start_acc |=> $stable(sad) && $stable(d1) && $stable(d2));

   assert_busy_in_replay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !in_ready);

   assert_sad_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> sad >= $past(sad));

   assert_res_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_data != {1'b1, {SW{1'b0}}});

endmodule

bind wseg_eval wseg_eval_chk #(
   .SW   (SW),
   .SADW (SADW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_start  (in_start),
   .in_ready  (in_ready),
   .res_valid (res_valid),
   .res_data  (res_data),
   .done      (done),
   .d1        (d1),
   .d2        (d2),
   .sad       (sad)
);

// File: tb/wseg_eval_test.sv
module wseg_eval_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int SW   = 8;
   localparam int NMAX = 32;
   localparam int SADW = 18;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_start = 1'b0;
   logic [1:0]           in_size = '0;
   logic [SW-1:0]        in_sample = '0;
   logic                 in_seg = 1'b0;
   logic                 in_ready;
   logic                 res_valid;
   logic signed [SW:0]   res_data;
   logic                 done;
   logic [SW-1:0]        d1;
   logic [SW-1:0]        d2;
   logic [SADW-1:0]      sad;

   wseg_eval #(.SW(SW), .NMAX(NMAX), .SADW(SADW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
      .in_size(in_size), .in_sample(in_sample), .in_seg(in_seg),
      .in_ready(in_ready), .res_valid(res_valid), .res_data(res_data),
      .done(done), .d1(d1), .d2(d2), .sad(sad)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int smp [1024];
   bit sg  [1024];
   int ex_res [1024];
   int ex_d1, ex_d2, ex_sad;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void model(input int code);
      int n = 4 << code;
      int tot = n * n;
      int s [2] = '{0, 0};
      int c [2] = '{0, 0};
      int dv [2];
      int m;
      for (int i = 0; i < tot; i++) begin
         s[sg[i]] += smp[i];
         c[sg[i]] += 1;
      end
      m = (s[0] + s[1] + tot / 2) / tot;
      for (int k = 0; k < 2; k++)
         dv[k] = (c[k] == 0) ? m : (s[k] + c[k] / 2) / c[k];
      ex_d1 = dv[0];
      ex_d2 = dv[1];
      ex_sad = 0;
      for (int i = 0; i < tot; i++) begin
         ex_res[i] = smp[i] - dv[sg[i]];
         ex_sad += (ex_res[i] < 0) ? -ex_res[i] : ex_res[i];
      end
   endfunction

   task automatic drive_block(input int code, input int count);
      for (int i = 0; i < count; i++) begin
         @(negedge clk);
         in_valid  = 1'b1;
         in_start  = (i == 0);
         in_size   = 2'(code);
         in_sample = SW'(smp[i]);
         in_seg    = sg[i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_start = 1'b0;
   endtask

   task automatic collect(input int code, input string tag);
      int  n = 4 << code;
      int  tot = n * n;
      int  got = 0;
      int  bad = 0;
      int  first_bad_act = 0;
      int  first_bad_exp = 0;
      int  guard = 0;
      bit  fin = 1'b0;
      bit  prev_rv = 1'b0;
      bit  rdy_bad = 1'b0;
      while (!fin && guard < 20000) begin
         guard++;
         if (res_valid) begin
            int r = res_data;
            if (got < tot && r != ex_res[got]) begin
               if (bad == 0) begin
                  first_bad_act = r;
                  first_bad_exp = ex_res[got];
               end
               bad++;
            end
            if (in_ready) rdy_bad = 1'b1;
            got++;
         end
         if (done) begin
            fin = 1'b1;
            chk(prev_rv, "R8", {tag, " done one cycle after last residual"}, 0, 1);
         end
         prev_rv = res_valid;
         if (!fin) @(negedge clk);
      end
      chk(fin, "R8", {tag, " done seen"}, fin, 1);
      chk(bad == 0, "R4", {tag, " residual value"}, first_bad_act, first_bad_exp);
      chk(got == tot, "R4", {tag, " residual count (R6 size)"}, got, tot);
      chk(!rdy_bad, "R7", {tag, " in_ready low during replay"}, rdy_bad, 0);
      chk(d1 == ex_d1, "R2", {tag, " d1"}, d1, ex_d1);
      chk(d2 == ex_d2, "R2", {tag, " d2"}, d2, ex_d2);
      chk(sad == ex_sad, "R5", {tag, " sad"}, sad, ex_sad);
   endtask

   task automatic run_block(input int code, input string tag);
      int n = 4 << code;
      model(code);
      drive_block(code, n * n);
      collect(code, tag);
   endtask

   task automatic fill_wedge(input int code);
      int n  = 4 << code;
      int x0 = int'($urandom_range(0, n - 1));
      int y0 = int'($urandom_range(0, n - 1));
      int dx = int'($urandom_range(0, 6)) - 3;
      int dy = int'($urandom_range(0, 6)) - 3;
      int a  = int'($urandom_range(0, 255));
      int b  = int'($urandom_range(0, 255));
      int nz = int'($urandom_range(0, 40));
      if (dx == 0 && dy == 0) dx = 1;
      for (int y = 0; y < n; y++)
         for (int x = 0; x < n; x++) begin
            int v;
            sg[y * n + x] = ((x - x0) * dy - (y - y0) * dx) > 0;
            v = (sg[y * n + x] ? b : a) + int'($urandom_range(0, 2 * nz)) - nz;
            smp[y * n + x] = (v < 0) ? 0 : (v > 255) ? 255 : v;
         end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int hd1, hd2, hsad;
      void'($urandom(32'h5eed_0417));

      repeat (3) @(negedge clk);
      chk(in_ready == 1'b1, "R7", "reset in_ready", in_ready, 1);
      chk(res_valid == 1'b0, "R4", "reset res_valid", res_valid, 0);
      chk(done == 1'b0, "R8", "reset done", done, 0);
      chk(sad == '0, "R5", "reset sad", sad, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: second segment empty, 4x4 ramp
      for (int i = 0; i < 16; i++) begin smp[i] = i * 16; sg[i] = 1'b0; end
      run_block(0, "R3 empty P2 4x4");
      chk(d2 == 120, "R3", "empty segment gets block mean", d2, 120);

      // R3: first segment empty, 8x8 random samples
      for (int i = 0; i < 64; i++) begin smp[i] = int'($urandom_range(0, 255)); sg[i] = 1'b1; end
      run_block(1, "R3 empty P1 8x8");

      // R2 rounding of a half, R5 largest distortion, 32x32
      for (int i = 0; i < 1024; i++) begin smp[i] = (i % 2) ? 255 : 0; sg[i] = 1'b0; end
      run_block(3, "R2 half rounding 32x32");
      chk(d1 == 128, "R2", "half rounds upward", d1, 128);
      chk(sad == 130560, "R5", "full-scale distortion", sad, 130560);

      // R1: perfect two-level fit, 16x16 diagonal split
      for (int y = 0; y < 16; y++)
         for (int x = 0; x < 16; x++) begin
            sg[y * 16 + x]  = (x + y) >= 16;
            smp[y * 16 + x] = sg[y * 16 + x] ? 10 : 200;
         end
      run_block(2, "R1 exact fit 16x16");
      chk(d1 == 200 && d2 == 10, "R1", "segment bit to fill mapping", {d1, d2}, {8'd200, 8'd10});
      chk(sad == 0, "R1", "exact fit distortion", sad, 0);

      // R6 and mixed patterns: random wedge blocks of every size
      for (int t = 0; t < 12; t++) begin
         int code = (t < 4) ? t : int'($urandom_range(0, 3));
         fill_wedge(code);
         run_block(code, "R6 random wedge");
      end

      // R7: unflagged samples while idle are ignored; R8 hold after done
      hd1 = d1; hd2 = d2; hsad = sad;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_start = 1'b0; in_size = 2'd3;
         in_sample = 8'hff; in_seg = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b1, "R7", "still idle after stray samples", in_ready, 1);
      chk(sad == hsad, "R7", "stray samples leave sad", sad, hsad);
      chk(d1 == hd1 && d2 == hd2, "R8", "fill values held", {d1, d2}, {8'(hd1), 8'(hd2)});
      fill_wedge(0);
      run_block(0, "R7 block after stray samples");

      // R9: restart in the middle of loading
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_start = (i == 0); in_size = 2'd3;
         in_sample = 8'(i * 13); in_seg = i[0];
      end
      fill_wedge(1);
      run_block(1, "R9 restart mid-load");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule